// File: doc/BRIEF.md
# Mesh Neighbor Link Port Unit

This unit lives inside one processing element of a two-dimensional mesh and moves 32-bit words to and from the four adjacent elements. Each of the four directions (north, east, west, south) has an outbound register owned by this unit and an inbound word that is the neighbor's outbound register seen across the link. A word written into an outbound register therefore becomes the neighbor's inbound word. Every outbound register carries a valid flag. The flag is set when the register is written and cleared when the neighbor signals that it has taken the word.

The unit executes one command per cycle from a small command port. A send places a source word into the outbound register of a chosen direction. The source is either a general register or one of the outbound registers. A get consumes the inbound word of a chosen direction and writes it either to a general register or to an outbound register. A forward copies any inbound word into any outbound register in one step, so that data can pass through this element toward one farther away. A command that cannot complete is held with a combinational stall until its operands are ready. General-register access goes through an external register file, with a read address, read data and a write port. General register 0 always reads as zero and is never written.

Top module: `mesh_link_unit`

## Requirements
- R1: After a synchronous active-high reset, all four outbound registers hold zero, all valid flags are clear, and no take, write or stall is asserted.
- R2: An accepted send (cmd_op = 1) loads the source word into outbound register cmd_dir and sets its valid flag. Both are visible at the clock edge that ends the accepting cycle. Lanes are N = 0, E = 1, W = 2, S = 3, and lane d occupies bits [32d+31:32d] of every flat link bus.
- R3: An accepted get (cmd_op = 2) pulses link_in_take for lane cmd_dir during the accepting cycle. When cmd_to_out = 0, it writes the inbound word to general register cmd_reg through rf_we, rf_waddr and rf_wdata. Only one take is ever asserted at a time, and only on a lane whose inbound valid is high.
- R4: A command stalls (cmd_stall = 1) and has no effect in these cases: a send to an outbound register whose valid flag is set; a get or forward whose inbound lane is not valid; a get to an outbound register, or a forward, whose destination outbound valid flag is set.
- R5: An outbound valid flag stays set, with its data unchanged, until link_out_take for that lane is high at a clock edge, and then clears. A take on a lane whose flag is clear changes nothing.
- R6: A general-register source with cmd_reg = 0 reads as zero, whatever the register file returns. A get to register 0 still consumes the inbound word but asserts no register-file write.
- R7: With cmd_to_out = 1, the general-register operand is replaced by outbound register cmd_alt. For a send, that register is the source. For a get, it is the destination.
- R8: A forward (cmd_op = 3) copies inbound lane cmd_dir into outbound register cmd_alt for every one of the 16 lane pairs, and consumes the inbound word.
- R9: A get captures the inbound word present before the accepting clock edge. A neighbor update made at that same edge is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 2 | 0 idle, 1 send, 2 get, 3 forward |
| cmd_dir | input | 2 | Link lane: send target, or get/forward source |
| cmd_alt | input | 2 | Outbound register operand, or forward destination |
| cmd_to_out | input | 1 | Operand is outbound register cmd_alt instead of a general register |
| cmd_reg | input | REG_AW | General register index |
| cmd_stall | output | 1 | Command held this cycle |
| rf_raddr | output | REG_AW | Register file read address |
| rf_rdata | input | DATA_W | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REG_AW | Register file write address |
| rf_wdata | output | DATA_W | Register file write data |
| link_in_data | input | 4*DATA_W | Neighbors' outbound words |
| link_in_valid | input | 4 | Neighbors' outbound valid flags |
| link_in_take | output | 4 | Consume pulse to each neighbor |
| link_out_data | output | 4*DATA_W | This unit's outbound registers |
| link_out_valid | output | 4 | This unit's outbound valid flags |
| link_out_take | input | 4 | Neighbor has consumed the outbound word |

## Verification
The two functions that can fall in the same cycle are a neighbor's take of an outbound register and a local send aimed at that same register. A second pairing is a get and the neighbor refreshing the word it reads. The bench holds a send against a full register and raises the take in that cycle. It then confirms that the stall persists for that cycle, lifts in the next one, and that the new word lands only afterwards. For the get case, it changes the inbound word at the accepting edge and expects the general register to hold the earlier word.

// File: rtl/mesh_link_pkg.sv
package mesh_link_pkg;

    localparam int LINK_W     = 32;
    localparam int NUM_LANES  = 4;
    localparam int LANE_IW    = 2;
    localparam int GPR_AW     = 5;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_SEND = 2'd1,
        OP_GET  = 2'd2,
        OP_FWD  = 2'd3
    } link_op_e;

    typedef enum logic [1:0] {
        LANE_N = 2'd0,
        LANE_E = 2'd1,
        LANE_W = 2'd2,
        LANE_S = 2'd3
    } lane_e;

    typedef struct packed {
        logic               valid;
        link_op_e           op;
        logic [LANE_IW-1:0] lane;
        logic [LANE_IW-1:0] alt;
        logic               to_out;
    } link_cmd_t;

    typedef struct packed {
        logic               blocked;
        logic               take;
        logic               out_wr;
        logic [LANE_IW-1:0] out_lane;
        logic               gpr_wr;
        logic               src_in;
    } link_action_t;

    function automatic logic [NUM_LANES-1:0] lane_onehot(input logic [LANE_IW-1:0] l);
        logic [NUM_LANES-1:0] m;
        m = '0;
        m[l] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/mesh_link_ctrl.sv
module mesh_link_ctrl
    import mesh_link_pkg::*;
#(
    parameter int DATA_W = LINK_W,
    parameter int REG_AW = GPR_AW
) (
    input  link_cmd_t                      cmd,
    input  logic [REG_AW-1:0]              cmd_reg,
    input  logic [NUM_LANES*DATA_W-1:0]    in_data,
    input  logic [NUM_LANES-1:0]           in_valid,
    input  logic [NUM_LANES*DATA_W-1:0]    out_data,
    input  logic [NUM_LANES-1:0]           out_valid,
    input  logic [DATA_W-1:0]              rf_rdata,
    output logic                           stall,
    output logic [NUM_LANES-1:0]           in_take,
    output logic [NUM_LANES-1:0]           out_wr,
    output logic [DATA_W-1:0]              out_wdata,
    output logic                           rf_we,
    output logic [REG_AW-1:0]              rf_waddr,
    output logic [DATA_W-1:0]              rf_wdata
);

    link_action_t       act;
    logic               go;
    logic [DATA_W-1:0]  in_word;
    logic [DATA_W-1:0]  alt_word;
    logic [DATA_W-1:0]  gpr_word;

    // Operand selection: inbound lane, outbound register, general register
    assign in_word  = in_data[cmd.lane*DATA_W +: DATA_W];
    assign alt_word = out_data[cmd.alt*DATA_W +: DATA_W];
    assign gpr_word = (cmd_reg == '0) ? '0 : rf_rdata;

    // Decode the operation into an action and its blocking condition
    always_comb begin
        act = '0;
        unique case (cmd.op)
            OP_SEND: begin
                act.blocked  = out_valid[cmd.lane];
                act.out_wr   = 1'b1;
                act.out_lane = cmd.lane;
            end
            OP_GET: begin
                act.blocked  = !in_valid[cmd.lane] ||
                               (cmd.to_out && out_valid[cmd.alt]);
                act.take     = 1'b1;
                act.src_in   = 1'b1;
                act.out_wr   = cmd.to_out;
                act.out_lane = cmd.alt;
                act.gpr_wr   = !cmd.to_out && (cmd_reg != '0);
            end
            OP_FWD: begin
                act.blocked  = !in_valid[cmd.lane] || out_valid[cmd.alt];
                act.take     = 1'b1;
                act.src_in   = 1'b1;
                act.out_wr   = 1'b1;
                act.out_lane = cmd.alt;
            end
            default: act = '0;
        endcase
    end

    assign go    = cmd.valid && !act.blocked;
    assign stall = cmd.valid && act.blocked;

    assign in_take = (go && act.take)   ? lane_onehot(cmd.lane)     : '0;
    assign out_wr  = (go && act.out_wr) ? lane_onehot(act.out_lane) : '0;

    always_comb begin
        if (act.src_in)
            out_wdata = in_word;
        else if (cmd.to_out)
            out_wdata = alt_word;
        else
            out_wdata = gpr_word;
    end

    assign rf_we    = go && act.gpr_wr;
    assign rf_waddr = cmd_reg;
    assign rf_wdata = in_word;

endmodule

// File: rtl/mesh_link_outreg.sv
module mesh_link_outreg
    import mesh_link_pkg::*;
#(
    parameter int DATA_W = LINK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (wr) begin
            data_q  <= wdata;
            valid_q <= 1'b1;
        end else if (take) begin
            valid_q <= 1'b0;
        end
    end

    // R4: the controller never writes a full outbound register
    a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        wr |-> !valid_q);

    // R2: a write lands with its data and the flag at the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr |=> (valid_q && data_q == $past(wdata)));

    // R5: a full register holds until taken
    a_r5_held_until_take: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !take) |=> (valid_q && $stable(data_q)));

    // R5: a take clears the flag
    a_r5_take_clears: assert property (@(posedge clk) disable iff (rst)
        (valid_q && take) |=> !valid_q);

    // R5: a take on an empty register changes nothing
    a_r5_empty_take_inert: assert property (@(posedge clk) disable iff (rst)
        (!valid_q && !wr) |=> (!valid_q && $stable(data_q)));

endmodule

// File: rtl/mesh_link_unit.sv
module mesh_link_unit
    import mesh_link_pkg::*;
#(
    parameter int DATA_W = LINK_W,
    parameter int REG_AW = GPR_AW
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid,
    input  logic [1:0]                    cmd_op,
    input  logic [1:0]                    cmd_dir,
    input  logic [1:0]                    cmd_alt,
    input  logic                          cmd_to_out,
    input  logic [REG_AW-1:0]             cmd_reg,
    output logic                          cmd_stall,
    output logic [REG_AW-1:0]             rf_raddr,
    input  logic [DATA_W-1:0]             rf_rdata,
    output logic                          rf_we,
    output logic [REG_AW-1:0]             rf_waddr,
    output logic [DATA_W-1:0]             rf_wdata,
    input  logic [NUM_LANES*DATA_W-1:0]   link_in_data,
    input  logic [NUM_LANES-1:0]          link_in_valid,
    output logic [NUM_LANES-1:0]          link_in_take,
    output logic [NUM_LANES*DATA_W-1:0]   link_out_data,
    output logic [NUM_LANES-1:0]          link_out_valid,
    input  logic [NUM_LANES-1:0]          link_out_take
);

    link_cmd_t              cmd;
    logic [NUM_LANES-1:0]   out_wr;
    logic [DATA_W-1:0]      out_wdata;

    assign cmd = '{valid:  cmd_valid,
                   op:     link_op_e'(cmd_op),
                   lane:   cmd_dir,
                   alt:    cmd_alt,
                   to_out: cmd_to_out};

    assign rf_raddr = cmd_reg;

    mesh_link_ctrl #(
        .DATA_W (DATA_W),
        .REG_AW (REG_AW)
    ) u_ctrl (
        .cmd       (cmd),
        .cmd_reg   (cmd_reg),
        .in_data   (link_in_data),
        .in_valid  (link_in_valid),
        .out_data  (link_out_data),
        .out_valid (link_out_valid),
        .rf_rdata  (rf_rdata),
        .stall     (cmd_stall),
        .in_take   (link_in_take),
        .out_wr    (out_wr),
        .out_wdata (out_wdata),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        mesh_link_outreg #(
            .DATA_W (DATA_W)
        ) u_outreg (
            .clk     (clk),
            .rst     (rst),
            .wr      (out_wr[g]),
            .wdata   (out_wdata),
            .take    (link_out_take[g]),
            .data_q  (link_out_data[g*DATA_W +: DATA_W]),
            .valid_q (link_out_valid[g])
        );
    end

    // R4: a stalled command touches neither the links nor the register file
    a_r4_stall_inert: assert property (@(posedge clk) disable iff (rst)
        cmd_stall |-> (link_in_take == '0 && out_wr == '0 && !rf_we));

    // R6: register 0 is never written
    a_r6_r0_never_written: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != '0));

    // R3: at most one take, and only on a valid inbound lane
    a_r3_one_take: assert property (@(posedge clk) disable iff (rst)
        $onehot0(link_in_take));

    a_r3_take_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (link_in_take & ~link_in_valid) == '0);

endmodule

// File: tb/mesh_link_unit_bench.sv
module mesh_link_unit_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_valid;
    logic [1:0]   cmd_op, cmd_dir, cmd_alt;
    logic         cmd_to_out;
    logic [4:0]   cmd_reg;
    logic         cmd_stall;
    logic [4:0]   rf_raddr, rf_waddr;
    logic [31:0]  rf_rdata, rf_wdata;
    logic         rf_we;
    logic [127:0] link_in_data, link_out_data;
    logic [3:0]   link_in_valid, link_in_take, link_out_valid, link_out_take;

    logic [31:0]  rf [32];
    int           checks = 0;
    int           errors = 0;
    bit           done = 0;

    always #10 clk = ~clk;

    mesh_link_unit u_mesh_link_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dir(cmd_dir), .cmd_alt(cmd_alt), .cmd_to_out(cmd_to_out),
        .cmd_reg(cmd_reg), .cmd_stall(cmd_stall), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .link_in_data(link_in_data),
        .link_in_valid(link_in_valid), .link_in_take(link_in_take),
        .link_out_data(link_out_data), .link_out_valid(link_out_valid),
        .link_out_take(link_out_take)
    );

    function automatic logic [31:0] rf_init(input int i);
        return (i == 0) ? 32'hDEAD_BEEF : (32'hA500_0000 ^ (32'(i) * 32'h0001_0203));
    endfunction

    // Bench-side register file model
    assign rf_rdata = rf[rf_raddr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) rf[i] <= rf_init(i);
        end else if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setcmd(input logic [1:0] op, input logic [1:0] d, input logic [1:0] a,
                          input logic to, input logic [4:0] r);
        cmd_valid = 1'b1; cmd_op = op; cmd_dir = d; cmd_alt = a; cmd_to_out = to; cmd_reg = r;
    endtask

    task automatic clearcmd();
        cmd_valid = 1'b0; cmd_op = 2'd0; cmd_dir = 2'd0; cmd_alt = 2'd0; cmd_to_out = 1'b0; cmd_reg = 5'd0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] d, input logic [1:0] a,
                         input logic to, input logic [4:0] r);
        setcmd(op, d, a, to, r);
        tick();
        clearcmd();
    endtask

    task automatic take_out(input int d);
        link_out_take[d] = 1'b1;
        tick();
        link_out_take = '0;
    endtask

    function automatic logic [31:0] olane(input int d);
        return link_out_data[32*d +: 32];
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, keep;
        rst = 1'b1;
        clearcmd();
        link_in_data = '0; link_in_valid = '0; link_out_take = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(link_out_valid == 4'b0, "R1 valid", 32'(link_out_valid), 32'h0);
        chk(link_out_data == '0, "R1 data", link_out_data[31:0], 32'h0);
        chk(!cmd_stall && link_in_take == '0 && !rf_we, "R1 idle outputs",
            {cmd_stall, link_in_take, rf_we}, 32'h0);

        // R2 send sweep from general registers
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 3; k++) begin
                int idx;
                idx = (k == 0) ? 1 : (k == 1) ? 7 : 31;
                issue(2'd1, 2'(d), 2'd0, 1'b0, 5'(idx));
                chk(olane(d) == rf_init(idx), "R2 send data", olane(d), rf_init(idx));
                chk(link_out_valid == (4'b1 << d), "R2 send valid", 32'(link_out_valid), 32'(4'b1 << d));
                take_out(d);
                chk(link_out_valid == 4'b0, "R5 take clears", 32'(link_out_valid), 32'h0);
            end
        end

        // R5 take on an empty register is ignored
        take_out(0);
        chk(link_out_valid == 4'b0 && olane(0) == rf_init(31), "R5 empty take ignored", olane(0), rf_init(31));

        // R4/R5 send to a full register, take arrives in the stalled cycle
        issue(2'd1, 2'd2, 2'd0, 1'b0, 5'd3);
        setcmd(2'd1, 2'd2, 2'd0, 1'b0, 5'd4);
        #1 chk(cmd_stall == 1'b1, "R4 send to full stalls", 32'(cmd_stall), 32'h1);
        link_out_take[2] = 1'b1;
        tick();
        link_out_take = '0;
        chk(olane(2) == rf_init(3), "R4 stalled send no effect", olane(2), rf_init(3));
        chk(cmd_stall == 1'b0, "R5 stall lifts after take", 32'(cmd_stall), 32'h0);
        tick();
        clearcmd();
        chk(olane(2) == rf_init(4) && link_out_valid[2], "R2 send after take", olane(2), rf_init(4));
        take_out(2);

        // R3 get sweep into general registers
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 3; k++) begin
                int idx;
                idx = (k == 0) ? 2 : (k == 1) ? 9 : 30;
                v = 32'h5000_0000 + 32'(d * 16 + idx);
                link_in_data[32*d +: 32] = v;
                link_in_valid[d] = 1'b1;
                setcmd(2'd2, 2'(d), 2'd0, 1'b0, 5'(idx));
                #1 chk(link_in_take == (4'b1 << d) && !cmd_stall, "R3 take pulse",
                       32'(link_in_take), 32'(4'b1 << d));
                tick();
                clearcmd();
                link_in_valid = '0;
                chk(rf[idx] == v, "R3 get writes register", rf[idx], v);
            end
        end

        // R4 get with no inbound word
        keep = rf[5];
        setcmd(2'd2, 2'd1, 2'd0, 1'b0, 5'd5);
        #1 chk(cmd_stall && link_in_take == '0, "R4 get empty stalls", {cmd_stall, link_in_take}, 32'h10);
        tick();
        clearcmd();
        chk(rf[5] == keep, "R4 stalled get no write", rf[5], keep);

        // R6 get into register 0, then send from register 0
        link_in_data[96 +: 32] = 32'h1234_5678;
        link_in_valid[3] = 1'b1;
        setcmd(2'd2, 2'd3, 2'd0, 1'b0, 5'd0);
        #1 chk(link_in_take == 4'b1000 && !rf_we, "R6 r0 get consumes no write",
               {link_in_take, rf_we}, 32'h10);
        tick();
        clearcmd();
        link_in_valid = '0;
        chk(rf[0] == 32'hDEAD_BEEF, "R6 r0 unchanged", rf[0], 32'hDEAD_BEEF);
        issue(2'd1, 2'd0, 2'd0, 1'b0, 5'd0);
        chk(olane(0) == 32'h0 && link_out_valid[0], "R6 r0 reads zero", olane(0), 32'h0);
        take_out(0);

        // R8 forward over all 16 lane pairs
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 4; e++) begin
                v = 32'hF000_0000 | 32'(s << 8) | 32'(e);
                link_in_data[32*s +: 32] = v;
                link_in_valid[s] = 1'b1;
                issue(2'd3, 2'(s), 2'(e), 1'b0, 5'd0);
                link_in_valid = '0;
                chk(olane(e) == v && link_out_valid == (4'b1 << e), "R8 forward", olane(e), v);
                take_out(e);
            end
        end

        // R7 get into an outbound register, then send from it
        link_in_data[32 +: 32] = 32'hC0DE_0001;
        link_in_valid[1] = 1'b1;
        issue(2'd2, 2'd1, 2'd3, 1'b1, 5'd7);
        link_in_valid = '0;
        chk(olane(3) == 32'hC0DE_0001 && link_out_valid[3], "R7 get to outbound", olane(3), 32'hC0DE_0001);
        chk(rf[7] == rf_init(7), "R7 general register untouched", rf[7], rf_init(7));
        issue(2'd1, 2'd0, 2'd3, 1'b1, 5'd9);
        chk(olane(0) == 32'hC0DE_0001 && link_out_valid[0], "R7 send from outbound", olane(0), 32'hC0DE_0001);
        take_out(0);

        // R4 get to a full outbound register stalls
        link_in_valid[1] = 1'b1;
        setcmd(2'd2, 2'd1, 2'd3, 1'b1, 5'd0);
        #1 chk(cmd_stall && link_in_take == '0, "R4 get to full outbound stalls",
               {cmd_stall, link_in_take}, 32'h10);
        clearcmd();
        link_in_valid = '0;
        take_out(3);

        // R9 inbound word changes at the accepting edge
        link_in_data[64 +: 32] = 32'hAAAA_0001;
        link_in_valid[2] = 1'b1;
        setcmd(2'd2, 2'd2, 2'd0, 1'b0, 5'd12);
        @(posedge clk);
        link_in_data[64 +: 32] <= 32'hBBBB_0002;
        @(negedge clk);
        clearcmd();
        link_in_valid = '0;
        chk(rf[12] == 32'hAAAA_0001, "R9 get sees pre-edge word", rf[12], 32'hAAAA_0001);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule